// File: doc/BRIEF.md
# Iterative Restoring Integer Divider

This block divides one unsigned W-bit value by another and returns the quotient and the remainder. It computes one quotient bit per clock cycle. In each step the partial remainder is shifted left by one place and takes the next dividend bit, most significant bit first. The divisor is then subtracted on trial. If the difference is not negative, the remainder is replaced by the difference and a 1 enters the quotient from the bottom. If it is negative, the remainder is kept as it was and a 0 enters the quotient.

To use it, drive the operands together with a one-cycle `start_i` while the block is idle. The block is busy for exactly W cycles. It then raises `done_o` for one cycle, and the results stay on the outputs until the next accepted start. Division by zero needs no special handling: it returns an all-ones quotient and a remainder equal to the dividend, and no flag is raised.

Top module: `seq_divider`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R2: A `start_i` that arrives while the block is idle is accepted. In the next cycle `busy_o` is 1, and both `quotient_o` and `remainder_o` read 0.
- R3: A `start_i` that arrives while `busy_o` is 1 is ignored. The running division finishes at its original time and returns the result for its original operands.
- R4: After a start is accepted, `busy_o` stays 1 for exactly W cycles. At the end `done_o` is 1 for a single cycle, in the first cycle where `busy_o` is 0.
- R5: When `done_o` is 1 and the divisor is not zero, `quotient_o` equals the dividend divided by the divisor, rounded down.
- R6: When `done_o` is 1 and the divisor is not zero, `remainder_o` equals the dividend modulo the divisor, so it is less than the divisor.
- R7: With a zero divisor, `quotient_o` is all ones (2^W-1) and `remainder_o` equals the dividend.
- R8: While the block is idle and no start is accepted, `quotient_o` and `remainder_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; takes effect only while idle |
| dividend_i | input | W | Dividend, sampled when a start is accepted |
| divisor_i | input | W | Divisor, sampled when a start is accepted |
| busy_o | output | 1 | A division is in progress |
| done_o | output | 1 | One-cycle pulse after the last step |
| quotient_o | output | W | Quotient |
| remainder_o | output | W | Remainder |

## Verification
Some properties are checked by assertions on every cycle:
- the clearing of the outputs on an accepted start;
- the length of the busy window, measured by a counter in the checker;
- the single-cycle `done_o` pulse;
- the outputs holding while idle;
- at completion, the remainder lying below the divisor, or an all-ones quotient when the divisor is zero.

The exact values of the quotient and the remainder can only be shown by the bench's scenarios. These compare each result with the language's division and modulo operators. The scenarios cover:
- the 29 / 3 example;
- extreme operands;
- equal operands;
- a dividend smaller than the divisor;
- a zero dividend;
- a zero divisor;
- a second start issued in the middle of a run.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_step.sv
// One restoring iteration: shift in next dividend bit, trial-subtract divisor.
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic         dvd_msb_i,
  input  logic [W-1:0] dvs_i,
  input  logic [W-1:0] quo_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0]   shifted;
  logic [W+1:0] trial;
  logic         neg;

  always_comb begin
    shifted = {rem_i, dvd_msb_i};
    trial   = {1'b0, shifted} - {2'b00, dvs_i};
    neg     = trial[W+1];
    // either branch fits in W bits: shifted < dvs, or shifted - dvs < dvs
    rem_o   = neg ? shifted[W-1:0] : trial[W-1:0];
    quo_o   = {quo_i[W-2:0], ~neg};
  end
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: accepts start while idle, runs W steps, pulses done.
module div_ctrl #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import div_pkg::*;

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_RUN);
  assign busy_o   = step_o;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        state_q <= ST_RUN;
        cnt_q   <= STEPS;
      end else if (step_o) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o
);
  logic         accept, step;
  logic [W-1:0] dvd_q, dvs_q, rem_q, quo_q;
  logic [W-1:0] rem_nxt, quo_nxt;

  div_ctrl #(.W(W)) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  div_step #(.W(W)) i_step (
    .rem_i     (rem_q),
    .dvd_msb_i (dvd_q[W-1]),
    .dvs_i     (dvs_q),
    .quo_i     (quo_q),
    .rem_o     (rem_nxt),
    .quo_o     (quo_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q <= '0;
      dvs_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
    end else if (accept) begin
      dvd_q <= dividend_i;
      dvs_q <= divisor_i;
      rem_q <= '0;
      quo_q <= '0;
    end else if (step) begin
      dvd_q <= {dvd_q[W-2:0], 1'b0};
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] divisor_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] quotient_o,
  input logic [W-1:0] remainder_o
);
  int           run_len;
  logic [W-1:0] dvs_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len <= 0;
      dvs_cap <= '0;
    end else if (start_i && !busy_o) begin
      run_len <= 0;
      dvs_cap <= divisor_i;
    end else if (busy_o) begin
      run_len <= run_len + 1;
    end
  end

  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && quotient_o == '0 && remainder_o == '0));

  p_run_length_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_len == W));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));

  p_rem_below_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dvs_cap != '0) |-> (remainder_o < dvs_cap));

  p_div_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && dvs_cap == '0) |-> (quotient_o == '1));
endmodule

bind seq_divider seq_divider_chk #(.W(W)) i_seq_divider_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .divisor_i   (divisor_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 200000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] dividend_i = '0;
  logic [W-1:0] divisor_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] quotient_o, remainder_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  seq_divider #(.W(W)) i_seq_divider (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Runs one division; optionally fires a second start mid-run (R3).
  task automatic divide(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit restart);
    logic [W-1:0] exp_q, exp_r;
    int busy_cnt;
    bit seen_done;
    exp_q = (b == '0) ? '1 : a / b;
    exp_r = (b == '0) ? a : a % b;
    @(negedge clk_i);
    start_i    = 1'b1;
    dividend_i = a;
    divisor_i  = b;
    @(negedge clk_i);
    start_i    = 1'b0;
    dividend_i = ~a;
    divisor_i  = b + 1'b1;
    check("R2", "busy after start", W'(busy_o), W'(1));
    check("R2", "quotient cleared", quotient_o, '0);
    check("R2", "remainder cleared", remainder_o, '0);
    busy_cnt  = 1;
    seen_done = 1'b0;
    for (int i = 0; i < W + 8; i++) begin
      if (restart && i == 3) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o) begin
        seen_done = 1'b1;
        break;
      end
      if (busy_o) busy_cnt++;
    end
    check("R4", "done seen", W'(seen_done), W'(1));
    check("R4", "busy cycles", W'(busy_cnt), W'(W));
    check("R4", "busy low at done", W'(busy_o), W'(0));
    if (b == '0) begin
      check("R7", "div0 quotient", quotient_o, exp_q);
      check("R7", "div0 remainder", remainder_o, exp_r);
    end else begin
      check(restart ? "R3" : "R5", "quotient", quotient_o, exp_q);
      check(restart ? "R3" : "R6", "remainder", remainder_o, exp_r);
    end
    @(negedge clk_i);
    check("R4", "done single pulse", W'(done_o), W'(0));
    @(negedge clk_i);
    check("R8", "quotient held", quotient_o, exp_q);
    check("R8", "remainder held", remainder_o, exp_r);
  endtask

  task automatic test_reset;
    check("R1", "busy", W'(busy_o), W'(0));
    check("R1", "done", W'(done_o), W'(0));
    check("R1", "quotient", quotient_o, '0);
    check("R1", "remainder", remainder_o, '0);
  endtask

  task automatic test_example;  divide(W'(29), W'(3), 1'b0); endtask
  task automatic test_extremes;
    divide('1, W'(1), 1'b0);
    divide('1, '1, 1'b0);
    divide(W'(0), W'(7), 1'b0);
    divide(W'(5), W'(9), 1'b0);
    divide(W'(12345), W'(12345), 1'b0);
    divide({1'b1, {(W-1){1'b0}}}, W'(3), 1'b0);
  endtask
  task automatic test_div_zero;
    divide(W'(32'hdead_beef), '0, 1'b0);
    divide('0, '0, 1'b0);
  endtask
  task automatic test_busy_start; divide(W'(1000003), W'(97), 1'b1); endtask
  task automatic test_random;
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom) >> ($urandom % W);
      divide(a, b, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_example();
    test_extremes();
    test_div_zero();
    test_busy_start();
    test_random();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end
endmodule